// File: doc/BRIEF.md
# Power-Management Event Status and Interrupt Generator

This block collects power-management events and turns them into a single level-sensitive system control interrupt (SCI). Three hardware event lines (real-time-clock alarm, power button, global lock release) and an internal free-running timer each set a bit in a 16-bit event status register. A 16-bit enable register selects which pending events drive the interrupt. The interrupt stays high for as long as any enabled event is pending, and software lowers it by clearing the status bits.

Software reaches the registers through a 64-byte I/O window. A configuration port sets where the window sits and whether it decodes. The base comes from a 32-bit configuration word, and the low six bits of that word are ignored. A separate configuration byte turns decoding on and off. The timer is an up-counter. It raises its status event every time its most significant bit changes value, so a wrap-around is flagged.

Top module: `pm_evt_sci_top`

## Requirements
- R1: After reset, the status, enable and control registers and the timer are all zero, the window does not decode, and `sci` is low.
- R2: An I/O access hits the window only when bit 0 of configuration byte address 0x80 was last written as 1 and `io_addr` bits [15:6] equal bits [15:6] of the value last written to configuration address 0x40. A write outside the window changes nothing. A read outside the window returns 0.
- R3: Inside the window the registers sit at these byte offsets: 0x00 status, 0x02 enable, 0x04 control, 0x08 timer bits [15:0], 0x0A timer bits [31:16] with zero fill. Any other offset, including an odd one, reads 0 and ignores writes. `io_rdata` is combinational and is valid in the same cycle as `io_rd`.
- R4: The status and enable registers implement only these bits: bit 0 timer, bit 5 global lock, bit 8 power button, bit 10 RTC alarm (mask 0x0521). All other bits read 0.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged, and a set bit stays set until it is cleared.
- R6: Each event input sets its status bit on a rising edge only. While the input is held high, a cleared bit stays clear.
- R7: If an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R8: The timer counts up by one every clock after reset, wraps modulo 2^TMR_W, and ignores writes.
- R9: The timer status bit is set on the clock edge where the timer's top bit changes value, whether or not the timer enable is set.
- R10: `sci` is high exactly when (status AND enable AND 0x0521) is non-zero. While the timer is armed (enable bit 0 set, status bit 0 clear), a top-bit change raises `sci` on the next cycle.
- R11: The control register at offset 0x04 holds any 16-bit value written to it and has no effect on `sci`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (0x40 base word, 0x80 enable byte) |
| cfg_wdata | input | 32 | Configuration write data |
| io_addr | input | ADDR_W (16) | I/O byte address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, 0 when no read hits |
| evt_rtc | input | 1 | RTC alarm event line |
| evt_pwrbtn | input | 1 | Power button event line |
| evt_glbl | input | 1 | Global lock release event line |
| sci | output | 1 | Level system control interrupt |

## Verification
Two situations are the hardest to reach from the ports. The first is an event edge that lands in the same cycle as a write-one-to-clear of the same bit. The second is a timer top-bit change that occurs while the timer is armed, and one that occurs while it is not. The bench uses a 12-bit timer so that the top bit changes every 2048 cycles. It times an RTC rising edge so that it coincides with the clearing write. It runs for longer than one full timer wrap, first with the timer enable cleared and then with it set. A behavioural model follows every clock and checks both `sci` and the read data against the design in every cycle.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int TMR_BIT = 0;
  localparam int GBL_BIT = 5;
  localparam int PWR_BIT = 8;
  localparam int RTC_BIT = 10;
  localparam logic [15:0] EVT_MASK = 16'h0521;

  localparam int OFS_STS = 'h00;
  localparam int OFS_EN  = 'h02;
  localparam int OFS_CTL = 'h04;
  localparam int OFS_TLO = 'h08;
  localparam int OFS_THI = 'h0A;

  localparam logic [7:0] CFG_BASE_ADDR = 8'h40;
  localparam logic [7:0] CFG_WIN_ADDR  = 8'h80;

  function automatic logic [15:0] sts_next(input logic [15:0] cur,
                                           input logic [15:0] clr,
                                           input logic [15:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic sci_level(input logic [15:0] sts, input logic [15:0] en);
    return |(sts & en & EVT_MASK);
  endfunction
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              win_en,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  import pm_evt_pkg::*;

  localparam logic [31:0] BASE_MASK = ((32'd1 << ADDR_W) - 32'd1) & ~((32'd1 << OFS_W) - 32'd1);

  logic [31:0] base_q;
  logic        en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_BASE_ADDR) base_q <= cfg_wdata & BASE_MASK;
      if (cfg_addr == CFG_WIN_ADDR)  en_q   <= cfg_wdata[0];
    end
  end

  assign win_en = en_q;
  assign hit    = en_q && ((32'(io_addr) & BASE_MASK) == base_q);
  assign ofs    = io_addr[OFS_W-1:0];

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(base_q) && $stable(en_q)))
    else $error("p_cfg_hold_r2");
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] cnt,
  output logic             tmr_evt
);
  localparam int TOP = TMR_W - 1;

  logic [TMR_W-1:0] cnt_q;
  logic             live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      live_q <= 1'b1;
    end
  end

  // Top bit flips on the next edge when every lower bit is one.
  assign tmr_evt = &cnt_q[TOP-1:0];
  assign cnt     = cnt_q;

  p_tmr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("p_tmr_step_r8");

  p_top_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> (cnt_q[TOP] != $past(cnt_q[TOP])))
    else $error("p_top_flip_r9");
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  evt_in,   // [0] global lock, [1] power button, [2] RTC
  input  logic        tmr_evt,
  input  logic        sts_wr,
  input  logic        en_wr,
  input  logic        ctl_wr,
  input  logic [15:0] wdata,
  output logic [15:0] sts,
  output logic [15:0] en,
  output logic [15:0] ctl,
  output logic        sci
);
  import pm_evt_pkg::*;

  logic [15:0] sts_q, en_q, ctl_q;
  logic [2:0]  prev_q;
  logic [2:0]  rise;
  logic [15:0] set_vec, clr_vec;
  logic        tmr_armed;

  assign rise = evt_in & ~prev_q;

  always_comb begin
    set_vec          = '0;
    set_vec[TMR_BIT] = tmr_evt;
    set_vec[GBL_BIT] = rise[0];
    set_vec[PWR_BIT] = rise[1];
    set_vec[RTC_BIT] = rise[2];
    clr_vec          = sts_wr ? (wdata & EVT_MASK) : 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= evt_in;
      sts_q  <= sts_next(sts_q, clr_vec, set_vec);
      if (en_wr)  en_q  <= wdata & EVT_MASK;
      if (ctl_wr) ctl_q <= wdata;
    end
  end

  assign tmr_armed = en_q[TMR_BIT] && !sts_q[TMR_BIT];
  assign sci       = sci_level(sts_q, en_q);
  assign sts       = sts_q;
  assign en        = en_q;
  assign ctl       = ctl_q;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 16'h0) |=> ((sts_q & $past(set_vec)) == $past(set_vec)))
    else $error("p_set_wins_r7");

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> ((sts_q & $past(clr_vec & ~set_vec)) == 16'h0))
    else $error("p_w1c_r5");

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr && set_vec == 16'h0) |=> $stable(sts_q))
    else $error("p_hold_r5");

  p_tmr_sts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> sts_q[TMR_BIT])
    else $error("p_tmr_sts_r9");

  p_tmr_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_armed && tmr_evt) |=> sci)
    else $error("p_tmr_arm_r10");
endmodule

// File: rtl/pm_evt_sci_top.sv
module pm_evt_sci_top #(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 64,
  parameter int TMR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [15:0]       io_wdata,
  output logic [15:0]       io_rdata,
  input  logic              evt_rtc,
  input  logic              evt_pwrbtn,
  input  logic              evt_glbl,
  output logic              sci
);
  import pm_evt_pkg::*;

  localparam int OFS_W = $clog2(WIN_BYTES);

  logic             win_en, hit;
  logic [OFS_W-1:0] ofs;
  logic [TMR_W-1:0] tcnt;
  logic             tmr_evt;
  logic [15:0]      sts, en, ctl;
  logic [31:0]      tmr_ext;
  logic             wr_hit;

  pm_win_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_addr(io_addr), .win_en(win_en), .hit(hit), .ofs(ofs)
  );

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cnt(tcnt), .tmr_evt(tmr_evt)
  );

  assign wr_hit = io_wr && hit;

  pm_evt_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .evt_in({evt_rtc, evt_pwrbtn, evt_glbl}),
    .tmr_evt(tmr_evt),
    .sts_wr(wr_hit && ofs == OFS_W'(OFS_STS)),
    .en_wr (wr_hit && ofs == OFS_W'(OFS_EN)),
    .ctl_wr(wr_hit && ofs == OFS_W'(OFS_CTL)),
    .wdata(io_wdata),
    .sts(sts), .en(en), .ctl(ctl), .sci(sci)
  );

  assign tmr_ext = 32'(tcnt);

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit) begin
      if (ofs == OFS_W'(OFS_STS))      io_rdata = sts;
      else if (ofs == OFS_W'(OFS_EN))  io_rdata = en;
      else if (ofs == OFS_W'(OFS_CTL)) io_rdata = ctl;
      else if (ofs == OFS_W'(OFS_TLO)) io_rdata = tmr_ext[15:0];
      else if (ofs == OFS_W'(OFS_THI)) io_rdata = tmr_ext[31:16];
    end
  end

  p_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (io_rdata == 16'h0))
    else $error("p_win_r2");

  p_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 16'h0))
    else $error("p_noread_r3");
endmodule

// File: tb/pm_evt_sci_top_tb_top.sv
`timescale 1ns/1ps
module pm_evt_sci_top_tb_top;
  localparam int TW   = 12;
  localparam int TMOD = 1 << TW;
  localparam logic [15:0] MSK = 16'h0521;
  localparam logic [15:0] BASE = 16'h1200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        evt_rtc = 1'b0, evt_pwrbtn = 1'b0, evt_glbl = 1'b0;
  logic        sci;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [15:0] m_sts = 0, m_en = 0, m_ctl = 0, m_base = 0;
  logic        m_wen = 0, m_pr = 0, m_pp = 0, m_pg = 0;
  int          m_t = 0;

  always #2.5 clk = ~clk;

  pm_evt_sci_top #(.TMR_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .evt_rtc(evt_rtc), .evt_pwrbtn(evt_pwrbtn), .evt_glbl(evt_glbl), .sci(sci)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_hit();
    return m_wen && ((io_addr & 16'hFFC0) == m_base);
  endfunction

  function automatic logic [15:0] m_read();
    logic [15:0] v;
    v = 16'h0;
    if (io_rd && m_hit()) begin
      case (io_addr[5:0])
        6'h00: v = m_sts;
        6'h02: v = m_en;
        6'h04: v = m_ctl;
        6'h08: v = 16'(m_t);
        default: v = 16'h0;   // 0x0A reads zero for a 12-bit timer
      endcase
    end
    return v;
  endfunction

  // One clock: model update after the edge, comparison at the falling edge.
  task automatic tick();
    logic [15:0] setv, clrv;
    logic        h;
    int          oldt;
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_ctl = 0; m_base = 0; m_wen = 0;
      m_pr = 0; m_pp = 0; m_pg = 0; m_t = 0;
    end else begin
      h = m_hit();
      setv = 16'h0;
      oldt = m_t;
      m_t = (m_t + 1) % TMOD;
      if (((oldt >> (TW-1)) & 1) != ((m_t >> (TW-1)) & 1)) setv[0] = 1'b1;
      if (evt_glbl && !m_pg)   setv[5]  = 1'b1;
      if (evt_pwrbtn && !m_pp) setv[8]  = 1'b1;
      if (evt_rtc && !m_pr)    setv[10] = 1'b1;
      m_pg = evt_glbl; m_pp = evt_pwrbtn; m_pr = evt_rtc;
      clrv = (io_wr && h && io_addr[5:0] == 6'h00) ? (io_wdata & MSK) : 16'h0;
      m_sts = (m_sts & ~clrv) | setv;
      if (io_wr && h && io_addr[5:0] == 6'h02) m_en = io_wdata & MSK;
      if (io_wr && h && io_addr[5:0] == 6'h04) m_ctl = io_wdata;
      if (cfg_wr && cfg_addr == 8'h40) m_base = cfg_wdata[15:0] & 16'hFFC0;
      if (cfg_wr && cfg_addr == 8'h80) m_wen = cfg_wdata[0];
    end
    @(negedge clk);
    chk("R10 sci level", 32'(sci), 32'(|(m_sts & m_en & MSK)));
    chk("R3 R8 read data", 32'(io_rdata), 32'(m_read()));
  endtask

  task automatic idle();
    io_wr = 0; io_rd = 0; cfg_wr = 0;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; tick(); idle();
  endtask

  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    io_wr = 1; io_addr = a; io_wdata = d; tick(); idle();
  endtask

  task automatic io_read(input logic [15:0] a, output logic [15:0] d);
    io_rd = 1; io_addr = a; tick(); d = io_rdata; idle();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [15:0] d, d1;
    repeat (3) tick();
    rst_n = 1;
    chk("R1 sci after reset", 32'(sci), 0);
    io_read(BASE, d);
    chk("R2 read while window off", 32'(d), 0);

    cfg_write(8'h40, 32'hABCD_1234);   // base becomes 0x1200
    cfg_write(8'h80, 32'h0000_0001);
    io_read(BASE + 16'h00, d); chk("R1 status reset", 32'(d), 0);
    io_read(BASE + 16'h02, d); chk("R1 enable reset", 32'(d), 0);
    io_read(BASE + 16'h04, d); chk("R1 control reset", 32'(d), 0);
    io_read(BASE + 16'h0A, d); chk("R8 timer high zero", 32'(d), 0);

    io_write(BASE + 16'h02, 16'hFFFF);
    io_read(BASE + 16'h02, d); chk("R4 enable mask", 32'(d), 32'h0521);
    io_read(BASE + 16'h40, d); chk("R2 outside window", 32'(d), 0);
    io_read(BASE + 16'h03, d); chk("R3 odd offset", 32'(d), 0);

    evt_pwrbtn = 1; tick(); tick();
    chk("R10 sci from power button", 32'(sci), 1);
    io_read(BASE, d); chk("R6 power button set", 32'(d & 16'h0520), 32'h0100);
    io_write(BASE, 16'h0000);
    io_read(BASE, d); chk("R5 zero write keeps", 32'(d & 16'h0520), 32'h0100);
    io_write(BASE, 16'h0100);
    tick(); tick();
    io_read(BASE, d); chk("R6 held line no reset", 32'(d & 16'h0520), 0);
    evt_pwrbtn = 0; tick();

    evt_rtc = 1; tick(); evt_rtc = 0; tick();
    evt_rtc = 1; io_write(BASE, 16'h0400);
    io_read(BASE, d); chk("R7 set beats clear", 32'(d & 16'h0400), 32'h0400);
    evt_rtc = 0;
    io_write(BASE, 16'h0400);
    io_read(BASE, d); chk("R5 one write clears", 32'(d & 16'h0400), 0);

    evt_glbl = 1; tick(); evt_glbl = 0;
    io_read(BASE, d); chk("R4 global lock bit", 32'(d & 16'h0520), 32'h0020);

    io_write(BASE + 16'h04, 16'hBEEF);
    io_read(BASE + 16'h04, d); chk("R11 control holds", 32'(d), 32'hBEEF);

    io_read(BASE + 16'h08, d1);
    io_write(BASE + 16'h08, 16'h0000);
    io_read(BASE + 16'h08, d);
    chk("R8 timer ignores write", 32'(d), 32'((int'(d1) + 2) % TMOD));

    io_write(BASE + 16'h42, 16'h0000);
    io_read(BASE + 16'h02, d); chk("R2 alias write ignored", 32'(d), 32'h0521);
    cfg_write(8'h80, 32'h0);
    io_write(BASE, 16'hFFFF);
    io_read(BASE, d); chk("R2 disabled read", 32'(d), 0);
    cfg_write(8'h80, 32'h1);
    io_read(BASE, d); chk("R2 disabled write ignored", 32'(d & 16'h0020), 32'h0020);

    io_write(BASE + 16'h02, 16'h0000);
    io_write(BASE, 16'hFFFF);
    repeat (TMOD / 2 + 60) tick();
    io_read(BASE, d); chk("R9 timer status without enable", 32'(d & 16'h0001), 1);
    chk("R10 no sci when disabled", 32'(sci), 0);
    io_write(BASE + 16'h02, 16'h0001);
    chk("R10 sci from timer status", 32'(sci), 1);
    io_write(BASE, 16'h0001);
    chk("R10 sci drops after clear", 32'(sci), 0);
    repeat (TMOD + 100) tick();
    chk("R10 armed timer raises sci", 32'(sci), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule